// File: doc/BRIEF.md
# Three-Mode Timer / Event Counter

This block is a small counting peripheral with an 8-bit count register and a reload register. A control register selects one of three functions:

- **Interval timer.** The count advances on ticks from an internal time base, which is either the system clock divided by four or a slow oscillator input.
- **Event counter.** The count advances on one chosen edge of an external pin.
- **Pulse-width capture.** The count accumulates internal ticks only while the pin is inside a pulse of the programmed polarity.

In every mode, a step from the all-ones value reloads the count from the reload register. That step also emits an interrupt request, gated by an enable input.

Software writes the control and reload registers through simple write strobes and reads the control and count values back on output ports. The pin and the slow oscillator are asynchronous inputs. Both are resynchronised into the single system clock domain, and neither is used as a clock.

Top module: `tmr_evc`

## Requirements
- R1: After reset the control readback is 0x08, the count is 0x00, the reload value is 0x00 and the interrupt request is low.
- R2: A control write stores data bits [7:3], and bits [2:0] always read as zero. The fields are:
  - [7:6] selects the function: 00 idle, 01 event counter, 10 interval timer, 11 pulse-width capture.
  - [5] selects the time base: 0 is the system clock divided by four, 1 is the slow oscillator.
  - [4] is the run enable.
  - [3] is the edge polarity.
- R3: A reload write while the run enable is 0 also sets the count to the written value. While the run enable is 1 it changes only the reload register.
- R4: While the run enable is 0, or the function field is 00, the count holds its value.
- R5: In event-counter mode, polarity 0 counts rising edges of the pin and polarity 1 counts falling edges. A pin transition that is present before clock edge n changes the count at edge n+2.
- R6: With the divide-by-four time base, one tick occurs on every fourth clock edge after reset release, starting with the fourth. In interval-timer mode each tick adds one to the count.
- R7: With the slow time base, each falling edge of the slow oscillator input is one tick, with the same two-edge latency as the pin.
- R8: In capture mode with polarity 0, ticks are counted from a falling pin edge until the next rising edge. With polarity 1, they are counted from a rising edge until the next falling edge. Outside the pulse the count holds.
- R9: A count step taken from 0xFF loads the reload value instead of wrapping to zero.
- R10: The interrupt request goes high for exactly one cycle, in the cycle that follows a reload step, and only when the interrupt-enable input was 1 at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_reload | input | 1 | Write strobe for the reload register |
| wdata | input | 8 | Write data |
| evt_pin | input | 1 | External event / pulse pin (asynchronous) |
| slow_osc | input | 1 | Slow oscillator time base (asynchronous) |
| irq_en | input | 1 | Interrupt-request enable |
| ctrl_rd | output | 8 | Control register readback |
| count_rd | output | 8 | Count register readback |
| irq | output | 1 | One-cycle overflow interrupt request |

## Verification
Every piece of internal state in this block drives a port within a bounded time.

- **Edge detection or time base.** A wrong edge detector or tick generator appears on `count_rd` at the first counted edge or tick: two clock edges after a pin change, or at most four edges for the divided time base.
- **Capture flag.** A capture flag stuck in the wrong state shows as a count that moves outside the pulse, or that stays frozen inside it.
- **Reload and interrupt.** A bad reload register or interrupt gate becomes visible only at the overflow step. The bench therefore drives the count across 0xFF repeatedly, and compares `count_rd` and `irq` against a behavioural model on every clock.

// File: rtl/tmr_evc_pkg.sv
package tmr_evc_pkg;

  typedef enum logic [1:0] {
    FN_IDLE  = 2'b00,
    FN_EVENT = 2'b01,
    FN_TIMER = 2'b10,
    FN_PWCAP = 2'b11
  } tmr_fn_e;

  localparam int CTRL_W     = 8;
  localparam int FN_HI      = 7;
  localparam int FN_LO      = 6;
  localparam int SRC_BIT    = 5;
  localparam int RUN_BIT    = 4;
  localparam int POL_BIT    = 3;
  localparam int STORED_LO  = 3;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h08;

  typedef struct packed {
    tmr_fn_e fn;
    logic    slow_src;
    logic    run;
    logic    pol;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] r);
    tmr_ctrl_t c;
    c.fn       = tmr_fn_e'(r[FN_HI:FN_LO]);
    c.slow_src = r[SRC_BIT];
    c.run      = r[RUN_BIT];
    c.pol      = r[POL_BIT];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] mask_ctrl(input logic [CTRL_W-1:0] w);
    logic [CTRL_W-1:0] m;
    m = w;
    m[STORED_LO-1:0] = '0;
    return m;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_div_tick.sv
module tmr_div_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  // the divided clock falls as the phase wraps
  assign tick = (phase_q == LAST);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_evc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_reload,
  input  logic [DW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DW-1:0]     reload_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= mask_ctrl(wdata[CTRL_W-1:0]);
      if (wr_reload) reload_q <= wdata;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_evc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_ctrl_t     cfg,
  input  logic          pin_rise,
  input  logic          pin_fall,
  input  logic          tick,
  input  logic          wr_reload,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] reload_q,
  input  logic          irq_en,
  output logic [DW-1:0] count_q,
  output logic          step_evt,
  output logic          ovf_evt,
  output logic          meas_q,
  output logic          irq_q
);
  localparam logic [DW-1:0] FULL = '1;

  function automatic logic [DW-1:0] advance(input logic [DW-1:0] c,
                                            input logic [DW-1:0] r);
    return (c == FULL) ? r : c + 1'b1;
  endfunction

  logic cap_active, start_edge, stop_edge, pin_step;

  assign cap_active = cfg.run && (cfg.fn == FN_PWCAP);
  assign start_edge = cfg.pol ? pin_rise : pin_fall;
  assign stop_edge  = cfg.pol ? pin_fall : pin_rise;
  assign pin_step   = cfg.pol ? pin_fall : pin_rise;

  always_comb begin
    step_evt = 1'b0;
    if (cfg.run) begin
      unique case (cfg.fn)
        FN_EVENT: step_evt = pin_step;
        FN_TIMER: step_evt = tick;
        FN_PWCAP: step_evt = tick && meas_q;
        default:  step_evt = 1'b0;
      endcase
    end
  end

  assign ovf_evt = step_evt && (count_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      meas_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (step_evt)                    count_q <= advance(count_q, reload_q);
      else if (wr_reload && !cfg.run)  count_q <= wdata;

      if (!cap_active)      meas_q <= 1'b0;
      else if (start_edge)  meas_q <= 1'b1;
      else if (stop_edge)   meas_q <= 1'b0;

      irq_q <= ovf_evt && irq_en;
    end
  end
endmodule

// File: rtl/tmr_evc.sv
module tmr_evc
  import tmr_evc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SYS_DIV     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_reload,
  input  logic [DW-1:0] wdata,
  input  logic          evt_pin,
  input  logic          slow_osc,
  input  logic          irq_en,
  output logic [7:0]    ctrl_rd,
  output logic [DW-1:0] count_rd,
  output logic          irq
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] src_in, src_rise, src_fall;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     reload_q;
  tmr_ctrl_t         cfg;
  logic              div_tick, sel_tick;
  logic              step_evt, ovf_evt, meas_q;

  assign src_in = {slow_osc, evt_pin};

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src_in[g]),
      .rise (src_rise[g]),
      .fall (src_fall[g])
    );
  end

  tmr_div_tick #(.DIV(SYS_DIV)) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (div_tick)
  );

  tmr_regs #(.DW(DW)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_reload(wr_reload),
    .wdata    (wdata),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q)
  );

  assign cfg      = decode_ctrl(ctrl_q);
  assign sel_tick = cfg.slow_src ? src_fall[1] : div_tick;

  tmr_count_core #(.DW(DW)) i_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .pin_rise (src_rise[0]),
    .pin_fall (src_fall[0]),
    .tick     (sel_tick),
    .wr_reload(wr_reload),
    .wdata    (wdata),
    .reload_q (reload_q),
    .irq_en   (irq_en),
    .count_q  (count_rd),
    .step_evt (step_evt),
    .ovf_evt  (ovf_evt),
    .meas_q   (meas_q),
    .irq_q    (irq)
  );

  assign ctrl_rd = ctrl_q;
endmodule

// File: rtl/tmr_evc_chk.sv
module tmr_evc_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_reload,
  input logic          irq_en,
  input logic [7:0]    ctrl_rd,
  input logic [DW-1:0] count_rd,
  input logic [DW-1:0] reload_q,
  input logic          irq
);
  // R2
  ctrl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[2:0] == 3'b000);

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctrl_rd[4] || ctrl_rd[7:6] == 2'b00) && !wr_reload) |=> $stable(count_rd));

  // R9
  step_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[4] && !wr_reload) |=>
      (count_rd == $past(count_rd) || count_rd == $past(count_rd) + 1'b1 ||
       ($past(count_rd) == '1 && count_rd == $past(reload_q))));

  // R10
  irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(count_rd) == '1 && count_rd == $past(reload_q)));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

bind tmr_evc tmr_evc_chk #(.DW(DW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_reload(wr_reload),
  .irq_en   (irq_en),
  .ctrl_rd  (ctrl_rd),
  .count_rd (count_rd),
  .reload_q (reload_q),
  .irq      (irq)
);

// File: tb/test_tmr_evc.sv
module test_tmr_evc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ctrl = 1'b0, wr_reload = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       evt_pin = 1'b0, slow_osc = 1'b0, irq_en = 1'b0;
  logic [7:0] ctrl_rd, count_rd;
  logic       irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tmr_evc i_tmr_evc (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_reload(wr_reload),
    .wdata(wdata), .evt_pin(evt_pin), .slow_osc(slow_osc), .irq_en(irq_en),
    .ctrl_rd(ctrl_rd), .count_rd(count_rd), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  int   m_edges;
  int   m_ctrl, m_pre, m_cnt;
  bit   m_irq, m_meas, m_live;
  bit   pin_hist[$];
  bit   osc_hist[$];

  function automatic bit hist_at(ref bit q[$], input int ago);
    return q[ago];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edges = 0; m_ctrl = 8'h08; m_pre = 0; m_cnt = 0;
      m_irq = 0; m_meas = 0; m_live = 1;
      pin_hist = '{0, 0, 0};
      osc_hist = '{0, 0, 0};
    end else begin
      // a change is seen two edges after it is sampled
      bit p_r, p_f, o_f, tick, run, pol, adv;
      int fn;
      p_r = hist_at(pin_hist, 1) && !hist_at(pin_hist, 2);
      p_f = !hist_at(pin_hist, 1) && hist_at(pin_hist, 2);
      o_f = !hist_at(osc_hist, 1) && hist_at(osc_hist, 2);
      tick = ((m_ctrl >> 5) & 1) ? o_f : ((m_edges % 4) == 3);
      run  = (m_ctrl >> 4) & 1;
      pol  = (m_ctrl >> 3) & 1;
      fn   = (m_ctrl >> 6) & 3;
      adv  = 0;
      if (run && fn == 1) adv = pol ? p_f : p_r;
      if (run && fn == 2) adv = tick;
      if (run && fn == 3) adv = tick && m_meas;
      m_irq = adv && m_cnt == 255 && irq_en;
      if (!(run && fn == 3)) m_meas = 0;
      else if (pol ? p_r : p_f) m_meas = 1;
      else if (pol ? p_f : p_r) m_meas = 0;
      if (adv) m_cnt = (m_cnt == 255) ? m_pre : m_cnt + 1;
      else if (wr_reload && !run) m_cnt = wdata;
      if (wr_reload) m_pre = wdata;
      if (wr_ctrl) m_ctrl = wdata & 8'hF8;
      pin_hist.push_front(evt_pin); void'(pin_hist.pop_back());
      osc_hist.push_front(slow_osc); void'(osc_hist.pop_back());
      m_edges++;
    end
  end

  function automatic string count_tag(input int c);
    if (!((c >> 4) & 1)) return "R4";
    case ((c >> 6) & 3)
      1: return "R5";
      2: return ((c >> 5) & 1) ? "R7" : "R6";
      3: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_live && !finished) begin
      check("R2", ctrl_rd, m_ctrl);
      check(count_tag(m_ctrl), count_rd, m_cnt);
      check("R10", irq, m_irq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_ctrl(input logic [7:0] v);
    wr_ctrl = 1; wdata = v; cyc(1); wr_ctrl = 0;
  endtask

  task automatic put_reload(input logic [7:0] v);
    wr_reload = 1; wdata = v; cyc(1); wr_reload = 0;
  endtask

  task automatic pin_pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      evt_pin = 1; cyc(hi); evt_pin = 0; cyc(lo);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    n_fail++; n_tests++;
    $display("[TB] FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int dut_irqs, mdl_irqs;
    logic [7:0] held;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    check("R1", ctrl_rd, 8'h08);
    check("R1", count_rd, 8'h00);
    check("R1", irq, 0);

    // R2 low bits dropped
    put_ctrl(8'hFF);
    check("R2", ctrl_rd, 8'hF8);
    put_ctrl(8'h00);

    // R3 reload while halted sets count
    put_reload(8'h10);
    check("R3", count_rd, 8'h10);

    // R5 rising edges
    put_ctrl(8'h50);
    pin_pulses(5, 3, 3);
    check("R5", count_rd, 8'h15);
    // R5 falling edges
    put_ctrl(8'h58);
    pin_pulses(3, 3, 3);
    check("R5", count_rd, 8'h18);

    // R3 reload while running leaves count
    put_reload(8'hFD);
    cyc(2);
    check("R3", count_rd, 8'h18);

    // R4 halted: pin activity ignored
    put_ctrl(8'h48);
    pin_pulses(4, 3, 3);
    check("R4", count_rd, 8'h18);

    put_reload(8'hFD);
    check("R3", count_rd, 8'hFD);

    // R6 / R9 / R10 timer with divided base
    irq_en = 1;
    put_ctrl(8'h90);
    for (int i = 0; i < 60 && !irq; i++) cyc(1);
    check("R10", irq, 1);
    check("R9", count_rd, 8'hFD);
    dut_irqs = 0; mdl_irqs = 0;
    for (int i = 0; i < 48; i++) begin
      cyc(1);
      dut_irqs += irq; mdl_irqs += m_irq;
    end
    check("R10", dut_irqs, mdl_irqs);
    check("R10", dut_irqs > 0, 1);
    irq_en = 0;
    dut_irqs = 0;
    for (int i = 0; i < 48; i++) begin
      cyc(1);
      dut_irqs += irq;
    end
    check("R10", dut_irqs, 0);

    // R7 slow time base
    put_ctrl(8'h00);
    put_reload(8'h20);
    put_ctrl(8'hB0);
    for (int i = 0; i < 6; i++) begin
      slow_osc = 1; cyc(5); slow_osc = 0; cyc(5);
    end
    cyc(3);
    check("R7", count_rd, 8'h26);

    // R8 capture, polarity 0
    put_ctrl(8'h00);
    put_reload(8'h00);
    put_ctrl(8'hD0);
    evt_pin = 1; cyc(6);
    check("R8", count_rd, 8'h00);
    evt_pin = 0; cyc(40);
    evt_pin = 1; cyc(6);
    held = count_rd;
    check("R8", held >= 8'd9 && held <= 8'd11, 1);
    cyc(20);
    check("R8", count_rd, held);

    // R8 capture, polarity 1
    put_ctrl(8'h00);
    put_reload(8'h00);
    put_ctrl(8'hD8);
    evt_pin = 0; cyc(6);
    evt_pin = 1; cyc(24);
    evt_pin = 0; cyc(6);
    held = count_rd;
    check("R8", held >= 8'd5 && held <= 8'd7, 1);
    cyc(20);
    check("R8", count_rd, held);

    // R4 idle function with run set
    put_ctrl(8'h10);
    pin_pulses(5, 2, 2);
    cyc(8);
    check("R4", count_rd, held);

    cyc(2);
    finish_run();
  end
endmodule